// File: doc/BRIEF.md
# Table Entry Address Walker

This block turns a table index into the memory address of that table's entry. The table is described by a 64-bit base register value. The block captures and decodes that value when the unit is enabled. The decoded descriptor holds:

- a base address,
- a page size of 4, 16 or 64 KB,
- an entry size of 1 to 32 bytes,
- a flat or two-level layout flag,
- an entry count.

The entry count is clamped to a table-specific ID width. For a device table that width is `devbits_i`+1. For a collection table it is 16, unless `cil_i` selects `cidbits_i`+1.

A lookup is a one-cycle pulse on `lookup_i` with `index_i`. A flat table gives its answer arithmetically. A two-level table first needs one 8-byte pointer read through a request/response read port. The pointer then gives the second-level page that holds the entry.

Every lookup ends with a one-cycle `done_o` pulse. `result_o` and `entry_addr_o` carry the outcome:

| Code | Outcome |
|------|---------|
| 0 | address |
| 1 | pointer not mapped |
| 2 | memory error |
| 3 | index out of range |

`entry_addr_o` is meaningful only with outcome 0. Both outputs hold until the next `done_o`.

Base register layout:

| Bits | Field |
|------|-------|
| [7:0] | page count − 1 |
| [9:8] | page code: 0 = 4 KB, 1 = 16 KB, 2 or 3 = 64 KB |
| [47:12] | address field |
| [52:48] | entry size − 1 |
| [62] | two-level flag |
| [63] | valid |

All other bits are ignored.

Top module: `tbl_entry_walker`

## Requirements
- R1: For a flat table, an in-range lookup gives outcome 0 with address base + index × entry size. `done_o` rises one cycle after `lookup_i` is sampled, and no memory read is issued.
- R2: The base address is decoded per page size. For 4 KB and 16 KB pages it is bits [47:12] shifted left by 12. For 64 KB pages it is bits [47:16] shifted left by 16, OR'd with bits [15:12] shifted left by 48.
- R3: For a two-level table, an in-range lookup issues exactly one read at base + (index / (page size / 8)) × 8. `mem_req_o` and `mem_addr_o` hold steady until `mem_rvalid_i`.
- R4: If the pointer read succeeds with bit 63 clear, the outcome is 1 (not mapped).
- R5: If the pointer read returns `mem_rerr_i`, the outcome is 2, whatever the data holds.
- R6: A valid pointer gives outcome 0 with address (pointer bits [50:0]) + (index mod (page size / entry size)) × entry size. `done_o` rises one cycle after the response is sampled.
- R7: The entry count is pages × page size / entry size for a flat table. For a two-level table it is (pages × page size / 8) × (page size / entry size). An index at or above the count gives outcome 3 after one cycle, with no read.
- R8: The count is clamped to 2^w. For a device table (`collection_i`=0), w = `devbits_i`+1. For a collection table, w = `cidbits_i`+1 when `cil_i`=1, else 16.
- R9: With the valid bit clear, the count is zero. While the unit is disabled, every lookup gives outcome 3.
- R10: The descriptor is captured on the rising edge of `enable_i`. Changes to `base_reg_i` or the width inputs while enabled have no effect.
- R11: `done_o` is a single-cycle pulse, once per accepted lookup. A lookup pulse arriving while a pointer read is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Unit enable; its rising edge captures the descriptor |
| base_reg_i | input | 64 | Table base register value |
| collection_i | input | 1 | 1: collection table, 0: device table |
| devbits_i | input | 5 | Device ID width − 1 |
| cil_i | input | 1 | Selects the explicit collection ID width |
| cidbits_i | input | 5 | Collection ID width − 1 |
| lookup_i | input | 1 | Lookup request pulse |
| index_i | input | 32 | Table index |
| mem_req_o | output | 1 | Pointer read pending |
| mem_addr_o | output | 52 | Pointer read address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 64 | Read response data |
| mem_rerr_i | input | 1 | Read response error |
| done_o | output | 1 | Lookup complete pulse |
| result_o | output | 2 | Outcome code |
| entry_addr_o | output | 52 | Entry address |

## Verification
The hardest state to reach is a lookup pulse arriving while a pointer read is still pending. The same goes for the exact edges of the clamped entry count. The bench holds memory responses back for a random 0–3 cycles. During that wait it injects a second lookup pulse and checks that only one completion follows. Directed configurations place indices exactly at count − 1 and count under each clamp source. A responder mode forces an error with the valid bit set, to show that the error takes priority.

// File: rtl/tblwalk_pkg.sv
package tblwalk_pkg;
  localparam int ADDR_W  = 52;
  localparam int IDX_W   = 32;
  localparam int CNT_W   = 41;
  localparam int PTR_W   = 51;
  localparam int L2PP_W  = 17;
  localparam int REG_W   = 64;

  typedef enum logic [1:0] {
    RES_ADDR     = 2'd0,
    RES_UNMAPPED = 2'd1,
    RES_MEM_ERR  = 2'd2,
    RES_RANGE    = 2'd3
  } res_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [4:0]        page_lg;
    logic [5:0]        esz;
    logic              two_level;
    logic [CNT_W-1:0]  count;
    logic [L2PP_W-1:0] l2_per_page;
  } tbl_desc_t;
endpackage

// File: rtl/tbl_geom_decode.sv
module tbl_geom_decode
  import tblwalk_pkg::*;
(
  input  logic [REG_W-1:0] base_reg_i,
  input  logic             collection_i,
  input  logic [4:0]       devbits_i,
  input  logic             cil_i,
  input  logic [4:0]       cidbits_i,
  output tbl_desc_t        desc_o
);
  logic [8:0]        pages;
  logic [CNT_W-1:0]  span, flat_cnt, ind_cnt, raw_cnt, lim;
  logic [L2PP_W-1:0] l2pp;
  logic [5:0]        idbits;
  logic              unused_bits;

  assign unused_bits = ^{base_reg_i[61:53], base_reg_i[11:10]};

  always_comb begin
    desc_o = '0;
    case (base_reg_i[9:8])
      2'd0: begin
        desc_o.page_lg = 5'd12;
        desc_o.base    = {4'h0, base_reg_i[47:12], 12'h000};
      end
      2'd1: begin
        desc_o.page_lg = 5'd14;
        desc_o.base    = {4'h0, base_reg_i[47:12], 12'h000};
      end
      default: begin
        desc_o.page_lg = 5'd16;
        desc_o.base    = {base_reg_i[15:12], base_reg_i[47:16], 16'h0000};
      end
    endcase
    desc_o.esz       = {1'b0, base_reg_i[52:48]} + 6'd1;
    desc_o.two_level = base_reg_i[62];
    pages    = {1'b0, base_reg_i[7:0]} + 9'd1;
    span     = CNT_W'(pages) << desc_o.page_lg;
    flat_cnt = span / CNT_W'(desc_o.esz);
    l2pp     = (L2PP_W'(1) << desc_o.page_lg) / L2PP_W'(desc_o.esz);
    ind_cnt  = (span >> 3) * CNT_W'(l2pp);
    raw_cnt  = desc_o.two_level ? ind_cnt : flat_cnt;
    if (collection_i) idbits = cil_i ? {1'b0, cidbits_i} + 6'd1 : 6'd16;
    else              idbits = {1'b0, devbits_i} + 6'd1;
    lim      = CNT_W'(1) << idbits;
    desc_o.l2_per_page = l2pp;
    if (!base_reg_i[63])    desc_o.count = '0;
    else if (raw_cnt > lim) desc_o.count = lim;
    else                    desc_o.count = raw_cnt;
  end
endmodule

// File: rtl/tbl_addr_calc.sv
module tbl_addr_calc
  import tblwalk_pkg::*;
(
  input  tbl_desc_t         desc_i,
  input  logic [IDX_W-1:0]  index_i,
  output logic [ADDR_W-1:0] flat_addr_o,
  output logic [ADDR_W-1:0] l1_addr_o,
  output logic [ADDR_W-1:0] l2_off_o,
  output logic              in_range_o
);
  logic [IDX_W-1:0] slot, sub;

  assign slot        = index_i >> (desc_i.page_lg - 5'd3);
  assign sub         = index_i % IDX_W'(desc_i.l2_per_page);
  assign flat_addr_o = desc_i.base + ADDR_W'(index_i) * ADDR_W'(desc_i.esz);
  assign l1_addr_o   = desc_i.base + (ADDR_W'(slot) << 3);
  assign l2_off_o    = ADDR_W'(sub) * ADDR_W'(desc_i.esz);
  assign in_range_o  = CNT_W'(index_i) < desc_i.count;
endmodule

// File: rtl/tbl_entry_walker.sv
module tbl_entry_walker
  import tblwalk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [63:0]       base_reg_i,
  input  logic              collection_i,
  input  logic [4:0]        devbits_i,
  input  logic              cil_i,
  input  logic [4:0]        cidbits_i,
  input  logic              lookup_i,
  input  logic [31:0]       index_i,
  output logic              mem_req_o,
  output logic [51:0]       mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i,
  input  logic              mem_rerr_i,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [51:0]       entry_addr_o
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e               st_q;
  logic              en_q;
  tbl_desc_t         desc_d, desc_q;
  logic [ADDR_W-1:0] flat_addr, l1_addr, l2_off, off_q;
  logic              in_range;
  logic              unused_bits;

  assign unused_bits = ^mem_rdata_i[62:51];

  tbl_geom_decode u_dec (
    .base_reg_i   (base_reg_i),
    .collection_i (collection_i),
    .devbits_i    (devbits_i),
    .cil_i        (cil_i),
    .cidbits_i    (cidbits_i),
    .desc_o       (desc_d)
  );

  tbl_addr_calc u_calc (
    .desc_i      (desc_q),
    .index_i     (index_i),
    .flat_addr_o (flat_addr),
    .l1_addr_o   (l1_addr),
    .l2_off_o    (l2_off),
    .in_range_o  (in_range)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      desc_q <= '0;
    end else begin
      en_q <= enable_i;
      if (enable_i && !en_q) desc_q <= desc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      mem_req_o    <= 1'b0;
      mem_addr_o   <= '0;
      off_q        <= '0;
      done_o       <= 1'b0;
      result_o     <= RES_ADDR;
      entry_addr_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (lookup_i) begin
          if (!en_q || !in_range) begin
            done_o       <= 1'b1;
            result_o     <= RES_RANGE;
            entry_addr_o <= '0;
          end else if (!desc_q.two_level) begin
            done_o       <= 1'b1;
            result_o     <= RES_ADDR;
            entry_addr_o <= flat_addr;
          end else begin
            mem_req_o  <= 1'b1;
            mem_addr_o <= l1_addr;
            off_q      <= l2_off;
            st_q       <= ST_WAIT;
          end
        end
        ST_WAIT: if (mem_rvalid_i) begin
          mem_req_o <= 1'b0;
          done_o    <= 1'b1;
          st_q      <= ST_IDLE;
          if (mem_rerr_i) begin
            result_o     <= RES_MEM_ERR;
            entry_addr_o <= '0;
          end else if (!mem_rdata_i[63]) begin
            result_o     <= RES_UNMAPPED;
            entry_addr_o <= '0;
          end else begin
            result_o     <= RES_ADDR;
            entry_addr_o <= ADDR_W'(mem_rdata_i[PTR_W-1:0]) + off_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tbl_entry_walker_chk.sv
module tbl_entry_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic [51:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic [63:0] mem_rdata_i,
  input logic        mem_rerr_i,
  input logic        done_o,
  input logic [1:0]  result_o
);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_no_done_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o);

  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r6_resp_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=> (done_o && !mem_req_o));

  a_r5_err_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i && mem_rerr_i) |=> (result_o == 2'd2));

  a_r4_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i && !mem_rerr_i && !mem_rdata_i[63]) |=> (result_o == 2'd1));
endmodule

bind tbl_entry_walker tbl_entry_walker_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_rdata_i  (mem_rdata_i),
  .mem_rerr_i   (mem_rerr_i),
  .done_o       (done_o),
  .result_o     (result_o)
);

// File: tb/tbl_entry_walker_tb.sv
`timescale 1ns/1ps
module tbl_entry_walker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic [63:0] base_reg_i = '0;
  logic        collection_i = 1'b0;
  logic [4:0]  devbits_i = '0;
  logic        cil_i = 1'b0;
  logic [4:0]  cidbits_i = '0;
  logic        lookup_i = 1'b0;
  logic [31:0] index_i = '0;
  logic        mem_req_o;
  logic [51:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        mem_rerr_i = 1'b0;
  logic        done_o;
  logic [1:0]  result_o;
  logic [51:0] entry_addr_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int mem_mode = 0;   // 0 hashed, 1 error, 2 not valid, 3 valid
  bit cap_en = 0;
  logic [63:0] cap_reg;
  bit cap_coll, cap_cil;
  int cap_devb, cap_cidb;

  localparam logic [63:0] M52 = (64'd1 << 52) - 1;
  localparam logic [63:0] M51 = (64'd1 << 51) - 1;

  always #2.5 clk_i = ~clk_i;

  tbl_entry_walker u_dut (.*);

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_reg(bit v, bit ind, int pg, int esf, int sz, logic [35:0] af);
    return {v, ind, 9'h0, 5'(esf), af, 2'b00, 2'(pg), 8'(sz)};
  endfunction

  function automatic logic [63:0] pg_bytes(logic [63:0] r);
    return (r[9:8] == 0) ? 64'd4096 : (r[9:8] == 1) ? 64'd16384 : 64'd65536;
  endfunction

  function automatic logic [63:0] exp_base(logic [63:0] r);
    if (r[9:8] >= 2) return (((r >> 16) & 64'hFFFF_FFFF) << 16) | (((r >> 12) & 64'hF) << 48);
    return ((r >> 12) & 64'hF_FFFF_FFFF) << 12;
  endfunction

  function automatic logic [63:0] exp_esz(logic [63:0] r);
    return ((r >> 48) & 64'h1F) + 1;
  endfunction

  function automatic logic [63:0] exp_count(logic [63:0] r, bit coll, bit cil, int devb, int cidb);
    logic [63:0] pg = pg_bytes(r), np = (r & 64'hFF) + 1, raw, lim;
    int w;
    raw = r[62] ? ((np * pg) / 8) * (pg / exp_esz(r)) : (np * pg) / exp_esz(r);
    w   = coll ? (cil ? cidb + 1 : 16) : devb + 1;
    lim = 64'd1 << w;
    if (!r[63]) return 0;
    return (raw < lim) ? raw : lim;
  endfunction

  function automatic logic [63:0] l1_data(logic [63:0] a, output bit err);
    logic [63:0] ptr = (a * 64'h9E37_79B1) & M51 & ~64'h7;
    bit v = ((a >> 3) % 5) != 0;
    err = ((a >> 3) % 7) == 3;
    if (mem_mode == 1) begin err = 1; v = 1; end
    if (mem_mode == 2) begin err = 0; v = 0; end
    if (mem_mode == 3) begin err = 0; v = 1; end
    return {v, 12'hABC, ptr[50:0]};
  endfunction

  task automatic set_cfg(logic [63:0] r, bit coll, bit cil, int devb, int cidb);
    @(negedge clk_i);
    enable_i = 0;
    @(negedge clk_i);
    base_reg_i = r; collection_i = coll; cil_i = cil;
    devbits_i = 5'(devb); cidbits_i = 5'(cidb);
    enable_i = 1;
    @(negedge clk_i);
    cap_en = 1; cap_reg = r; cap_coll = coll; cap_cil = cil;
    cap_devb = devb; cap_cidb = cidb;
  endtask

  task automatic lookup(logic [31:0] idx, string rq, bit extra);
    logic [63:0] cnt, exp_a, l1a, dat, pg, es;
    logic [1:0] exp_r;
    bit exp_mem, seen = 0, served = 0, got = 0, e;
    int lat = 0, resp_c = 0, wait_n = $urandom_range(0, 3);
    cnt = cap_en ? exp_count(cap_reg, cap_coll, cap_cil, cap_devb, cap_cidb) : 0;
    pg = pg_bytes(cap_reg); es = exp_esz(cap_reg);
    exp_mem = 0; exp_a = 0;
    l1a = (exp_base(cap_reg) + ((64'(idx) / (pg / 8)) * 8)) & M52;
    if (64'(idx) >= cnt) exp_r = 2'd3;
    else if (!cap_reg[62]) begin
      exp_r = 2'd0;
      exp_a = (exp_base(cap_reg) + 64'(idx) * es) & M52;
    end else begin
      exp_mem = 1;
      dat = l1_data(l1a, e);
      if (e) exp_r = 2'd2;
      else if (!dat[63]) exp_r = 2'd1;
      else begin
        exp_r = 2'd0;
        exp_a = ((dat & M51) + (64'(idx) % (pg / es)) * es) & M52;
      end
    end
    @(negedge clk_i);
    lookup_i = 1; index_i = idx;
    for (int c = 1; c <= 60 && !got; c++) begin
      @(negedge clk_i);
      mem_rvalid_i = 0; lookup_i = 0;
      if (done_o) begin got = 1; lat = c; end
      else if (mem_req_o && !served) begin
        if (!seen) begin
          seen = 1;
          chk(mem_addr_o == l1a[51:0], "R3", "pointer read address", 64'(mem_addr_o), l1a);
          if (extra) begin lookup_i = 1; index_i = idx ^ 32'h1; end
        end
        if (wait_n == 0) begin
          mem_rvalid_i = 1; mem_rdata_i = l1_data(64'(mem_addr_o), e); mem_rerr_i = e;
          served = 1; resp_c = c;
        end else wait_n--;
      end
    end
    chk(got, rq, "done seen", 64'(got), 1);
    chk(seen == exp_mem, exp_mem ? "R3" : "R7", "memory read issued", 64'(seen), 64'(exp_mem));
    chk(lat == (exp_mem ? resp_c + 1 : 1), exp_mem ? "R6" : "R1", "done latency",
        64'(lat), 64'(exp_mem ? resp_c + 1 : 1));
    chk(result_o == exp_r, rq, "outcome", 64'(result_o), 64'(exp_r));
    if (exp_r == 2'd0) chk(64'(entry_addr_o) == exp_a, rq, "entry address", 64'(entry_addr_o), exp_a);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(!done_o && !mem_req_o, "R11", "quiet after done", {62'h0, done_o, mem_req_o}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    chk(!done_o && !mem_req_o && result_o == 0, "R11", "reset state",
        {61'h0, done_o, mem_req_o, result_o != 0}, 0);
    rst_ni = 1;
    // disabled unit
    cap_en = 0;
    lookup(0, "R9", 0);
    // flat, 4 KB, 8-byte entries, 2 pages -> 1024 entries
    set_cfg(mk_reg(1, 0, 0, 7, 1, 36'h1_2345_6789), 0, 0, 31, 0);
    lookup(0, "R1", 0); lookup(5, "R1", 0); lookup(1023, "R7", 0); lookup(1024, "R7", 0);
    // 64 KB decode, high nibble in use
    set_cfg(mk_reg(1, 0, 2, 3, 0, 36'hA_BCDE_F123), 0, 0, 31, 0);
    lookup(0, "R2", 0); lookup(3, "R2", 0);
    set_cfg(mk_reg(1, 0, 1, 15, 3, 36'h0_0F0F_0F0F), 0, 0, 31, 0);
    lookup(7, "R2", 0);
    // 24-byte entries, 1 page -> 170 entries
    set_cfg(mk_reg(1, 0, 0, 23, 0, 36'h0_0000_0100), 0, 0, 31, 0);
    lookup(169, "R7", 0); lookup(170, "R7", 0);
    // clamps
    set_cfg(mk_reg(1, 0, 0, 7, 0, 36'h0_0000_0200), 0, 0, 3, 0);
    lookup(15, "R8", 0); lookup(16, "R8", 0);
    mem_mode = 3;
    set_cfg(mk_reg(1, 1, 2, 7, 0, 36'h0_0001_0000), 1, 0, 0, 0);
    lookup(65535, "R8", 0); lookup(65536, "R8", 0);
    set_cfg(mk_reg(1, 1, 0, 7, 0, 36'h0_0001_0000), 1, 1, 0, 7);
    lookup(255, "R8", 0); lookup(256, "R8", 0);
    // valid bit clear
    set_cfg(mk_reg(0, 0, 0, 7, 0, 36'h0_0000_0300), 0, 0, 31, 0);
    lookup(0, "R9", 0);
    // two-level walks
    set_cfg(mk_reg(1, 1, 0, 7, 0, 36'h0_0004_0000), 0, 0, 31, 0);
    lookup(0, "R6", 0); lookup(511, "R6", 0); lookup(512, "R3", 0); lookup(1000, "R6", 1);
    mem_mode = 2; lookup(3, "R4", 0);
    mem_mode = 1; lookup(3, "R5", 0); lookup(700, "R5", 1);
    mem_mode = 3;
    // base register change while enabled has no effect
    @(negedge clk_i);
    base_reg_i = mk_reg(1, 0, 0, 0, 0, 36'h0); devbits_i = 0;
    lookup(777, "R10", 0);
    set_cfg(mk_reg(1, 0, 0, 0, 0, 36'h0), 0, 0, 0, 0);
    lookup(1, "R10", 0); lookup(2, "R10", 0);
    // random
    mem_mode = 0;
    for (int n = 0; n < 40; n++) begin
      logic [63:0] r, cnt;
      bit coll = 1'($urandom), cil = 1'($urandom);
      int devb = $urandom_range(2, 31), cidb = $urandom_range(2, 15);
      r = mk_reg(($urandom_range(0, 9) != 0), 1'($urandom), $urandom_range(0, 3),
                 $urandom_range(0, 31), $urandom_range(0, 7), 36'({$urandom, $urandom}));
      set_cfg(r, coll, cil, devb, cidb);
      cnt = exp_count(r, coll, cil, devb, cidb);
      for (int j = 0; j < 6; j++) begin
        logic [63:0] ix = (cnt == 0) ? 64'($urandom) : 64'($urandom) % (cnt + 2);
        if (j == 0 && cnt != 0) ix = cnt - 1;
        if (j == 1) ix = cnt;
        lookup(32'(ix), "R6", 1'($urandom));
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule